// File: doc/BRIEF.md
# USB Event Interrupt Flag Unit

This unit gathers the event pulses of a USB protocol engine into one byte of sticky flags and drives a single interrupt request line to the processor. The engine signals five kinds of event with one-cycle pulses: FIFO overflow, start-of-frame sent, suspend or wake, transfer complete, and either a bus reset (device role) or a connection change (host role). Software reads the flag byte and clears the flags it has handled by writing ones. A per-event enable mask selects which flags raise the interrupt.

When a transfer completes, the unit captures a status byte. The byte holds the token kind, a 4-bit field, the toggle-match result and the NAK-seen status. In the device role the 4-bit field is the endpoint number. In the host role it is the response PID, where 0000 means no response or a timeout. A busy-mode control makes the unit raise a hold output while the transfer-complete flag is still set. The engine uses this hold to answer NAK in the device role, or to postpone the next transaction in the host role. A clear-all control wipes every flag and requests a FIFO flush.

Top module: `usb_evt_irq_unit`

## Requirements
- R1: After a synchronous reset, the flag byte reads 0x20 (engine idle input high), the enable mask reads 0, the status byte reads 0, and irq, hold_xfer and fifo_flush_req are 0.
- R2: A one-cycle pulse on ev_pulse bit i sets flag bit i on the next clock edge, and the bit stays set afterwards. The bit map is: 0 bus reset or connection change, 1 transfer complete, 2 suspend or wake, 3 SOF sent, 4 FIFO overflow.
- R3: When flag_clr_wr is high, each 1 in flag_clr_mask clears the matching flag on the next edge. Flag bits whose mask bit is 0 keep their value.
- R4: If an event pulse and a software clear hit the same flag in the same cycle, the flag ends up set.
- R5: Flag bit 5 equals engine_idle as sampled at the previous clock edge.
- R6: On a transfer-complete pulse, the status byte captures {nak_seen, tog_ok, token[1:0], ep_or_pid[3:0]} at bits 7, 6, 5:4 and 3:0. The token codes are 00 OUT, 01 SOF, 10 IN and 11 SETUP. The status byte keeps that value until the next transfer-complete pulse. Flag bits 7 and 6 show the captured NAK and toggle-match bits.
- R7: irq is high exactly when some flag is set and its enable bit is set. irq follows a change of flag or enable one clock later.
- R8: hold_xfer rises on the same edge as the transfer-complete flag, provided busy_mode is high. It falls on the edge where that flag clears, or on the edge after busy_mode goes low.
- R9: While clear_all is high, every event flag is held at 0, and this overrides event pulses. fifo_flush_req follows clear_all one clock later.
- R10: When en_wr is high, the enable mask takes en_wr_data on the next edge and is read back on enable_reg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_pulse | input | 5 | One-cycle event pulses, one per flag bit |
| token | input | 2 | Token kind of the finishing transfer |
| ep_or_pid | input | 4 | Endpoint number (device role) or response PID (host role) |
| tog_ok | input | 1 | Data toggle matched on the finishing transfer |
| nak_seen | input | 1 | NAK seen on the finishing transfer |
| engine_idle | input | 1 | Protocol engine idle level |
| flag_clr_wr | input | 1 | Write strobe for the write-one-to-clear access |
| flag_clr_mask | input | 5 | Flags to clear |
| en_wr | input | 1 | Write strobe for the enable mask |
| en_wr_data | input | 5 | New enable mask |
| clear_all | input | 1 | Clear all flags and request a FIFO flush |
| busy_mode | input | 1 | Hold transfers while transfer-complete is pending |
| flag_reg | output | 8 | Flag byte |
| enable_reg | output | 5 | Enable mask |
| status_reg | output | 8 | Captured transfer status |
| irq | output | 1 | Interrupt request |
| hold_xfer | output | 1 | Hold request to the protocol engine |
| fifo_flush_req | output | 1 | FIFO flush request |

## Verification
Two functions can collide on one flag in the same cycle: the hardware setting it and software clearing it. The bench provokes this by pulsing FIFO overflow in the cycle where a write-one-to-clear targets that same bit, and it expects the flag to read set afterwards. A second clear on its own is then expected to empty the bit. A similar collision is created between clear-all and event pulses on every bit, including transfer complete, where clear-all is expected to win.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;
  localparam int EVT_W  = 5;
  localparam int FLAG_W = 8;
  localparam int TOK_W  = 2;
  localparam int FLD_W  = 4;

  localparam int EV_BUS  = 0;
  localparam int EV_XFER = 1;
  localparam int EV_SUSP = 2;
  localparam int EV_SOF  = 3;
  localparam int EV_OVF  = 4;

  localparam int BIT_IDLE = 5;
  localparam int BIT_TOG  = 6;
  localparam int BIT_NAK  = 7;

  typedef struct packed {
    logic             nak;
    logic             tog_ok;
    logic [TOK_W-1:0] token;
    logic [FLD_W-1:0] field;
  } xfer_stat_t;
endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
  parameter int NUM_EVT = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] ev_pulse,
  input  logic               clr_wr,
  input  logic [NUM_EVT-1:0] clr_mask,
  input  logic               clear_all,
  output logic [NUM_EVT-1:0] flags_d,
  output logic [NUM_EVT-1:0] flags_q
);
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
    logic sw_clr;
    assign sw_clr = clr_wr & clr_mask[i];
    // a hardware set beats a software clear; clear-all beats both
    assign flags_d[i] = clear_all ? 1'b0 : (ev_pulse[i] | (flags_q[i] & ~sw_clr));

    always_ff @(posedge clk) begin
      if (rst) flags_q[i] <= 1'b0;
      else     flags_q[i] <= flags_d[i];
    end
  end

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (!clear_all && ev_pulse != '0) |=> ((flags_q & $past(ev_pulse)) == $past(ev_pulse)));

  assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !clear_all) |=> ((flags_q & $past(clr_mask) & ~$past(ev_pulse)) == '0));

  assert_clear_all_R9: assert property (@(posedge clk) disable iff (rst)
    clear_all |=> (flags_q == '0));

  assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    (!clear_all && !clr_wr) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/evt_status_cap.sv
module evt_status_cap
  import usb_evt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       capture,
  input  xfer_stat_t stat_in,
  output xfer_stat_t stat_q
);
  always_ff @(posedge clk) begin
    if (rst)          stat_q <= '0;
    else if (capture) stat_q <= stat_in;
  end

  assert_status_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(stat_q));
endmodule

// File: rtl/evt_irq_gen.sv
module evt_irq_gen #(
  parameter int NUM_EVT = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_wr,
  input  logic [NUM_EVT-1:0] en_wr_data,
  input  logic [NUM_EVT-1:0] flags_q,
  input  logic               xfer_flag_d,
  input  logic               xfer_flag_q,
  input  logic               busy_mode,
  input  logic               clear_all,
  output logic [NUM_EVT-1:0] en_q,
  output logic               irq,
  output logic               hold,
  output logic               flush
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      irq   <= 1'b0;
      hold  <= 1'b0;
      flush <= 1'b0;
    end else begin
      if (en_wr) en_q <= en_wr_data;
      irq   <= |(flags_q & en_q);
      hold  <= busy_mode & xfer_flag_d;
      flush <= clear_all;
    end
  end

  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (flags_q == '0) |=> !irq);

  assert_hold_off_R8: assert property (@(posedge clk) disable iff (rst)
    !busy_mode |=> !hold);

  assert_hold_flag_R8: assert property (@(posedge clk) disable iff (rst)
    hold |-> xfer_flag_q);
endmodule

// File: rtl/usb_evt_irq_unit.sv
module usb_evt_irq_unit
  import usb_evt_pkg::*;
#(
  parameter int NUM_EVT = EVT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] ev_pulse,
  input  logic [TOK_W-1:0]   token,
  input  logic [FLD_W-1:0]   ep_or_pid,
  input  logic               tog_ok,
  input  logic               nak_seen,
  input  logic               engine_idle,
  input  logic               flag_clr_wr,
  input  logic [NUM_EVT-1:0] flag_clr_mask,
  input  logic               en_wr,
  input  logic [NUM_EVT-1:0] en_wr_data,
  input  logic               clear_all,
  input  logic               busy_mode,
  output logic [FLAG_W-1:0]  flag_reg,
  output logic [NUM_EVT-1:0] enable_reg,
  output logic [FLAG_W-1:0]  status_reg,
  output logic               irq,
  output logic               hold_xfer,
  output logic               fifo_flush_req
);
  logic [NUM_EVT-1:0] flags_d, flags_q;
  logic               idle_q;
  xfer_stat_t         stat_in, stat_q;

  always_ff @(posedge clk) begin
    if (rst) idle_q <= 1'b1;
    else     idle_q <= engine_idle;
  end

  evt_flag_bank #(.NUM_EVT(NUM_EVT)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .ev_pulse (ev_pulse),
    .clr_wr   (flag_clr_wr),
    .clr_mask (flag_clr_mask),
    .clear_all(clear_all),
    .flags_d  (flags_d),
    .flags_q  (flags_q)
  );

  assign stat_in = '{nak: nak_seen, tog_ok: tog_ok, token: token, field: ep_or_pid};

  evt_status_cap u_stat (
    .clk    (clk),
    .rst    (rst),
    .capture(ev_pulse[EV_XFER]),
    .stat_in(stat_in),
    .stat_q (stat_q)
  );

  evt_irq_gen #(.NUM_EVT(NUM_EVT)) u_irq (
    .clk        (clk),
    .rst        (rst),
    .en_wr      (en_wr),
    .en_wr_data (en_wr_data),
    .flags_q    (flags_q),
    .xfer_flag_d(flags_d[EV_XFER]),
    .xfer_flag_q(flags_q[EV_XFER]),
    .busy_mode  (busy_mode),
    .clear_all  (clear_all),
    .en_q       (enable_reg),
    .irq        (irq),
    .hold       (hold_xfer),
    .flush      (fifo_flush_req)
  );

  always_comb begin
    flag_reg                 = '0;
    flag_reg[NUM_EVT-1:0]    = flags_q;
    flag_reg[BIT_IDLE]       = idle_q;
    flag_reg[BIT_TOG]        = stat_q.tog_ok;
    flag_reg[BIT_NAK]        = stat_q.nak;
  end

  assign status_reg = stat_q;
endmodule

// File: tb/usb_evt_irq_unit_bench.sv
module usb_evt_irq_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int S_FLAG = 0, S_EN = 1, S_STAT = 2, S_IRQ = 3, S_HOLD = 4, S_FLUSH = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] ev = '0;
  logic [1:0] tok = '0;
  logic [3:0] fld = '0;
  logic       tog = 1'b0, nak = 1'b0, idle = 1'b1;
  logic       fwe = 1'b0, ewe = 1'b0, clr = 1'b0, busy = 1'b0;
  logic [4:0] fmask = '0, ewd = '0;
  logic [7:0] flag_reg, status_reg;
  logic [4:0] enable_reg;
  logic       irq, hold_xfer, fifo_flush_req;

  int cyc = 0, total = 0, bad = 0;
  bit done = 1'b0;

  typedef struct {
    int         due;
    int         sel;
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  usb_evt_irq_unit u_usb_evt_irq_unit (
    .clk(clk), .rst(rst), .ev_pulse(ev), .token(tok), .ep_or_pid(fld),
    .tog_ok(tog), .nak_seen(nak), .engine_idle(idle),
    .flag_clr_wr(fwe), .flag_clr_mask(fmask), .en_wr(ewe), .en_wr_data(ewd),
    .clear_all(clr), .busy_mode(busy), .flag_reg(flag_reg), .enable_reg(enable_reg),
    .status_reg(status_reg), .irq(irq), .hold_xfer(hold_xfer), .fifo_flush_req(fifo_flush_req)
  );

  task automatic push(input int off, input int sel, input logic [7:0] exp, input string req);
    item_t it;
    it.due = cyc + off; it.sel = sel; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  task automatic next();
    @(negedge clk);
    ev = '0; fwe = 1'b0; ewe = 1'b0;
  endtask

  function automatic logic [7:0] observe(input int sel);
    case (sel)
      S_FLAG:  return flag_reg;
      S_EN:    return {3'b000, enable_reg};
      S_STAT:  return status_reg;
      S_IRQ:   return {7'd0, irq};
      S_HOLD:  return {7'd0, hold_xfer};
      default: return {7'd0, fifo_flush_req};
    endcase
  endfunction

  // monitor: compare scoreboard items as they fall due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      logic [7:0] act;
      it = sb.pop_front();
      act = observe(it.sel);
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s sel=%0d actual=%h expected=%h cycle=%0d", it.req, it.sel, act, it.exp, cyc);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    push(1, S_FLAG, 8'h20, "R1"); push(1, S_EN, 8'h00, "R1"); push(1, S_STAT, 8'h00, "R1");
    push(1, S_IRQ, 8'h00, "R1"); push(1, S_HOLD, 8'h00, "R1"); push(1, S_FLUSH, 8'h00, "R1");
    // R2 SOF pulse sets bit 3, enables still off
    next(); ev = 5'b01000;
    push(1, S_FLAG, 8'h28, "R2"); push(2, S_IRQ, 8'h00, "R7");
    // R10 enable write, R7 irq one cycle later
    next(); ewe = 1'b1; ewd = 5'b11111;
    push(1, S_EN, 8'h1F, "R10"); push(1, S_FLAG, 8'h28, "R2"); push(2, S_IRQ, 8'h01, "R7");
    // R3 write-one-to-clear with untouched bits
    next(); ev = 5'b00001; push(1, S_FLAG, 8'h29, "R2");
    next(); fwe = 1'b1; fmask = 5'b01000; push(1, S_FLAG, 8'h21, "R3");
    next(); fwe = 1'b1; fmask = 5'b00001; push(1, S_FLAG, 8'h20, "R3"); push(2, S_IRQ, 8'h00, "R7");
    // R4 set and clear in the same cycle
    next(); ev = 5'b10000; fwe = 1'b1; fmask = 5'b10000; push(1, S_FLAG, 8'h30, "R4");
    next(); fwe = 1'b1; fmask = 5'b10000; push(1, S_FLAG, 8'h20, "R4");
    // R5 idle mirror
    next(); idle = 1'b0; push(1, S_FLAG, 8'h00, "R5");
    next(); idle = 1'b1; push(1, S_FLAG, 8'h20, "R5");
    // R6 / R8 capture and hold, device role IN on endpoint 3
    next(); busy = 1'b1; ev = 5'b00010; tok = 2'b10; fld = 4'h3; tog = 1'b1; nak = 1'b0;
    push(1, S_STAT, 8'h63, "R6"); push(1, S_FLAG, 8'h62, "R6"); push(1, S_HOLD, 8'h01, "R8");
    next(); tok = 2'b11; fld = 4'hA; tog = 1'b0; nak = 1'b1;
    push(1, S_STAT, 8'h63, "R6"); push(1, S_HOLD, 8'h01, "R8");
    next(); fwe = 1'b1; fmask = 5'b00010;
    push(1, S_HOLD, 8'h00, "R8"); push(1, S_FLAG, 8'h60, "R3");
    // host role: no response PID 0000, SOF token
    next(); ev = 5'b00010; tok = 2'b01; fld = 4'h0; tog = 1'b0; nak = 1'b1;
    push(1, S_STAT, 8'h90, "R6"); push(1, S_FLAG, 8'hA2, "R6"); push(1, S_HOLD, 8'h01, "R8");
    next(); busy = 1'b0; push(1, S_HOLD, 8'h00, "R8");
    // R9 clear-all overrides events
    next(); clr = 1'b1; ev = 5'b11111;
    push(1, S_FLAG, 8'hA0, "R9"); push(1, S_FLUSH, 8'h01, "R9");
    next(); ev = 5'b00100; push(1, S_FLAG, 8'hA0, "R9"); push(1, S_FLUSH, 8'h01, "R9");
    next(); clr = 1'b0; push(1, S_FLUSH, 8'h00, "R9"); push(1, S_FLAG, 8'hA0, "R9");
    // R7 enable gates irq
    next(); ewe = 1'b1; ewd = 5'b00000;
    next(); ev = 5'b00100; push(1, S_FLAG, 8'hA4, "R2"); push(2, S_IRQ, 8'h00, "R7");
    next(); ewe = 1'b1; ewd = 5'b00100; push(1, S_EN, 8'h04, "R10"); push(2, S_IRQ, 8'h01, "R7");
    repeat (4) next();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule